// File: doc/BRIEF.md
# Register-Relative Effective Address Unit

This unit turns an addressing-mode request into a 32-bit operand address for a processor's load/store path. It covers absolute short and long addresses and the register-based modes: plain indirect, auto-increment, auto-decrement, signed 16-bit offset, and signed 8-bit offset plus an index register that may be scaled. The base may be an address register or the program counter.

Each request is accepted on a rising clock edge when `req_valid` is high. One cycle later the result appears on registered outputs: the effective address, the new base value, and a write-back enable for the register file. The increment and decrement steps follow the operand size. A byte access through the stack pointer (register 7) steps by two so that the pointer stays even. Memory fetches and the memory-indirect modes are handled elsewhere.

Top module: `ea_calc`

## Requirements
- R1: Mode code 0 (absolute short) yields the low 16 bits of `disp_i` sign-extended to 32 bits. 0x8000 gives 0xFFFF8000 and 0x7FFF gives 0x00007FFF, whatever the upper bits of `disp_i` hold.
- R2: Mode code 1 (absolute long) yields all 32 bits of `disp_i`. Mode code 2 (indirect) yields `base_i`.
- R3: Mode code 3 (auto-increment) yields `base_i` as the address and `base_i + step` as the new base. The step is 1, 2 or 4 for size codes 0 (byte), 1 (word) and 2 or 3 (long).
- R4: Mode code 4 (auto-decrement) yields `base_i - step` as both the address and the new base.
- R5: In modes 3 and 4 with `reg_num_i` equal to 7, `base_pc_i` low and size code 0, the step is 2 instead of 1.
- R6: Mode code 5 adds the low 16 bits of `disp_i`, sign-extended, to `base_i`.
- R7: Mode code 6 adds the low 8 bits of `disp_i` (sign-extended), `base_i` and the index. With `idx_long_i` low, the index is the low 16 bits of `idx_i` sign-extended; with it high, the index is the full 32 bits.
- R8: In mode 6 the extended index is multiplied by 2 raised to `scale_i` (1, 2, 4 or 8) before the addition. All sums wrap modulo 2^32.
- R9: When `base_pc_i` is high, modes 5 and 6 use the program-counter value on `base_i` with the same arithmetic, and the stack-pointer rule of R5 does not apply.
- R10: `base_we_o` is high only for modes 3 and 4 with `base_pc_i` low. It is low for every other mode and whenever `res_valid_o` is low.
- R11: The outputs register a request one cycle after it is accepted. `res_valid_o` follows `req_valid` with one cycle of delay. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| mode_i | input | 3 | Addressing-mode code 0..6 |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| reg_num_i | input | 3 | Base register number |
| base_pc_i | input | 1 | Base is the program counter |
| base_i | input | 32 | Base register or PC value |
| idx_i | input | 32 | Index register value |
| idx_long_i | input | 1 | Index uses all 32 bits |
| scale_i | input | 2 | Index shift amount 0..3 |
| disp_i | input | 32 | Displacement or absolute address |
| res_valid_o | output | 1 | Result present |
| ea_o | output | 32 | Effective address |
| base_next_o | output | 32 | Updated base value |
| base_we_o | output | 1 | Write the updated base back |

## Verification
The assertions check, on every clock edge, the one-cycle valid latency, that the write-back enable never appears without a valid result or outside the auto-update modes, that an auto-increment address equals the base presented one cycle earlier, that an auto-decrement address equals the new base, that a short absolute address is sign-extended, and that a byte access through the stack pointer keeps an even pointer even. The directed scenarios are what show the exact sums. These are the sign-extension boundaries of the offsets and the index, each scale factor, the per-size step values, the stack-pointer exception, PC-relative bases and wrap-around.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [2:0] {
        AM_ABS_SHORT = 3'd0,
        AM_ABS_LONG  = 3'd1,
        AM_INDIRECT  = 3'd2,
        AM_POST_INC  = 3'd3,
        AM_PRE_DEC   = 3'd4,
        AM_OFFSET16  = 3'd5,
        AM_INDEXED   = 3'd6,
        AM_RESERVED  = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        OS_BYTE  = 2'd0,
        OS_WORD  = 2'd1,
        OS_LONG  = 2'd2,
        OS_LONG2 = 2'd3
    } osize_e;
endpackage

// File: rtl/ea_step.sv
module ea_step #(
    parameter int AW     = 32,
    parameter int RNW    = 3,
    parameter int SP_REG = 7
) (
    input  logic [1:0]     size_i,
    input  logic [RNW-1:0] reg_num_i,
    input  logic           base_pc_i,
    output logic [AW-1:0]  step_o
);
    import ea_pkg::*;

    logic is_stack;

    always_comb begin
        is_stack = (reg_num_i == RNW'(SP_REG)) && !base_pc_i;
        unique case (osize_e'(size_i))
            OS_BYTE: step_o = is_stack ? AW'(2) : AW'(1);
            OS_WORD: step_o = AW'(2);
            default: step_o = AW'(4);
        endcase
    end
endmodule

// File: rtl/ea_index.sv
module ea_index #(
    parameter int AW = 32,
    parameter int SW = 2
) (
    input  logic [AW-1:0] idx_i,
    input  logic          idx_long_i,
    input  logic [SW-1:0] scale_i,
    output logic [AW-1:0] idx_scaled_o
);
    localparam int HW = 16;

    logic [AW-1:0] idx_ext;

    always_comb begin
        idx_ext      = idx_long_i ? idx_i : {{(AW-HW){idx_i[HW-1]}}, idx_i[HW-1:0]};
        idx_scaled_o = idx_ext << scale_i;
    end
endmodule

// File: rtl/ea_core.sv
module ea_core #(
    parameter int AW = 32
) (
    input  logic [2:0]    mode_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] disp_i,
    input  logic [AW-1:0] step_i,
    input  logic [AW-1:0] idx_scaled_i,
    input  logic          base_pc_i,
    output logic [AW-1:0] ea_o,
    output logic [AW-1:0] base_next_o,
    output logic          base_we_o
);
    import ea_pkg::*;

    localparam int HW = 16;
    localparam int BW = 8;

    logic [AW-1:0] d16_ext;
    logic [AW-1:0] d8_ext;
    logic [AW-1:0] dec_val;

    always_comb begin
        d16_ext     = {{(AW-HW){disp_i[HW-1]}}, disp_i[HW-1:0]};
        d8_ext      = {{(AW-BW){disp_i[BW-1]}}, disp_i[BW-1:0]};
        dec_val     = base_i - step_i;
        ea_o        = base_i;
        base_next_o = base_i;
        base_we_o   = 1'b0;
        unique case (amode_e'(mode_i))
            AM_ABS_SHORT: ea_o = d16_ext;
            AM_ABS_LONG:  ea_o = disp_i;
            AM_POST_INC: begin
                ea_o        = base_i;
                base_next_o = base_i + step_i;
                base_we_o   = !base_pc_i;
            end
            AM_PRE_DEC: begin
                ea_o        = dec_val;
                base_next_o = dec_val;
                base_we_o   = !base_pc_i;
            end
            AM_OFFSET16:  ea_o = base_i + d16_ext;
            AM_INDEXED:   ea_o = base_i + d8_ext + idx_scaled_i;
            default:      ea_o = base_i;
        endcase
    end
endmodule

// File: rtl/ea_calc.sv
module ea_calc #(
    parameter int AW     = 32,
    parameter int RNW    = 3,
    parameter int SW     = 2,
    parameter int SP_REG = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [2:0]     mode_i,
    input  logic [1:0]     size_i,
    input  logic [RNW-1:0] reg_num_i,
    input  logic           base_pc_i,
    input  logic [AW-1:0]  base_i,
    input  logic [AW-1:0]  idx_i,
    input  logic           idx_long_i,
    input  logic [SW-1:0]  scale_i,
    input  logic [AW-1:0]  disp_i,
    output logic           res_valid_o,
    output logic [AW-1:0]  ea_o,
    output logic [AW-1:0]  base_next_o,
    output logic           base_we_o
);
    logic [AW-1:0] step_w;
    logic [AW-1:0] idx_scaled_w;
    logic [AW-1:0] ea_w;
    logic [AW-1:0] next_w;
    logic          we_w;

    ea_step #(.AW(AW), .RNW(RNW), .SP_REG(SP_REG)) u_step (
        .size_i    (size_i),
        .reg_num_i (reg_num_i),
        .base_pc_i (base_pc_i),
        .step_o    (step_w)
    );

    ea_index #(.AW(AW), .SW(SW)) u_index (
        .idx_i        (idx_i),
        .idx_long_i   (idx_long_i),
        .scale_i      (scale_i),
        .idx_scaled_o (idx_scaled_w)
    );

    ea_core #(.AW(AW)) u_core (
        .mode_i       (mode_i),
        .base_i       (base_i),
        .disp_i       (disp_i),
        .step_i       (step_w),
        .idx_scaled_i (idx_scaled_w),
        .base_pc_i    (base_pc_i),
        .ea_o         (ea_w),
        .base_next_o  (next_w),
        .base_we_o    (we_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            ea_o        <= '0;
            base_next_o <= '0;
            base_we_o   <= 1'b0;
        end else begin
            res_valid_o <= req_valid;
            ea_o        <= ea_w;
            base_next_o <= next_w;
            base_we_o   <= req_valid && we_w;
        end
    end
endmodule

// File: rtl/ea_calc_chk.sv
module ea_calc_chk #(
    parameter int AW     = 32,
    parameter int RNW    = 3,
    parameter int SP_REG = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic [2:0]     mode_i,
    input logic [1:0]     size_i,
    input logic [RNW-1:0] reg_num_i,
    input logic           base_pc_i,
    input logic [AW-1:0]  base_i,
    input logic           res_valid_o,
    input logic [AW-1:0]  ea_o,
    input logic [AW-1:0]  base_next_o,
    input logic           base_we_o
);
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid_o);

    a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid_o);

    a_r10_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        base_we_o |-> res_valid_o);

    a_r10_we_only_update_modes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_i != 3'd3 && mode_i != 3'd4) |=> !base_we_o);

    a_r3_postinc_uses_base: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_i == 3'd3) |=> (ea_o == $past(base_i)));

    a_r4_predec_ea_is_new_base: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_i == 3'd4) |=> (ea_o == base_next_o));

    a_r1_short_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_i == 3'd0) |=> (ea_o[AW-1:16] == {(AW-16){ea_o[15]}}));

    a_r5_stack_stays_even: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (mode_i == 3'd3 || mode_i == 3'd4) && size_i == 2'd0
         && reg_num_i == RNW'(SP_REG) && !base_pc_i && !base_i[0])
        |=> !base_next_o[0]);
endmodule

bind ea_calc ea_calc_chk #(.AW(AW), .RNW(RNW), .SP_REG(SP_REG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .mode_i      (mode_i),
    .size_i      (size_i),
    .reg_num_i   (reg_num_i),
    .base_pc_i   (base_pc_i),
    .base_i      (base_i),
    .res_valid_o (res_valid_o),
    .ea_o        (ea_o),
    .base_next_o (base_next_o),
    .base_we_o   (base_we_o)
);

// File: tb/ea_calc_tb.sv
module ea_calc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [1:0]  size_i = '0;
    logic [2:0]  reg_num_i = '0;
    logic        base_pc_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [31:0] idx_i = '0;
    logic        idx_long_i = 1'b0;
    logic [1:0]  scale_i = '0;
    logic [31:0] disp_i = '0;
    logic        res_valid_o;
    logic [31:0] ea_o;
    logic [31:0] base_next_o;
    logic        base_we_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    ea_calc u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode_i(mode_i),
        .size_i(size_i), .reg_num_i(reg_num_i), .base_pc_i(base_pc_i),
        .base_i(base_i), .idx_i(idx_i), .idx_long_i(idx_long_i),
        .scale_i(scale_i), .disp_i(disp_i), .res_valid_o(res_valid_o),
        .ea_o(ea_o), .base_next_o(base_next_o), .base_we_o(base_we_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Drive on a falling edge; result is registered at the next rising edge
    // and sampled at the falling edge after it.
    task automatic issue(input logic [2:0] m, input logic [1:0] sz, input logic [2:0] rn,
                         input logic pc, input logic [31:0] b, input logic [31:0] x,
                         input logic xl, input logic [1:0] sc, input logic [31:0] d);
        req_valid = 1'b1; mode_i = m; size_i = sz; reg_num_i = rn; base_pc_i = pc;
        base_i = b; idx_i = x; idx_long_i = xl; scale_i = sc; disp_i = d;
        @(negedge clk);
        chk("R11 valid", {31'd0, res_valid_o}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R11 reset valid", {31'd0, res_valid_o}, 32'd0);
        chk("R11 reset ea", ea_o, 32'd0);
        chk("R11 reset next", base_next_o, 32'd0);
        chk("R11 reset we", {31'd0, base_we_o}, 32'd0);
    endtask

    task automatic t_absolute();
        issue(3'd0, 2'd1, 3'd0, 1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0000_8000);
        chk("R1 short 8000", ea_o, 32'hFFFF_8000);
        chk("R10 short we", {31'd0, base_we_o}, 32'd0);
        issue(3'd0, 2'd1, 3'd0, 1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 32'h0000_7FFF);
        chk("R1 short 7FFF", ea_o, 32'h0000_7FFF);
        issue(3'd0, 2'd1, 3'd0, 1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 32'h1234_8001);
        chk("R1 short upper ignored", ea_o, 32'hFFFF_8001);
        issue(3'd1, 2'd2, 3'd0, 1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 32'h1234_5678);
        chk("R2 long", ea_o, 32'h1234_5678);
    endtask

    task automatic t_indirect();
        issue(3'd2, 2'd2, 3'd2, 1'b0, 32'd2000, 32'h0, 1'b0, 2'd0, 32'h55);
        chk("R2 indirect ea", ea_o, 32'd2000);
        chk("R10 indirect we", {31'd0, base_we_o}, 32'd0);
    endtask

    task automatic t_postinc();
        issue(3'd3, 2'd0, 3'd1, 1'b0, 32'h1000, 32'h0, 1'b0, 2'd0, 32'h0);
        chk("R3 byte ea", ea_o, 32'h1000);
        chk("R3 byte next", base_next_o, 32'h1001);
        chk("R10 postinc we", {31'd0, base_we_o}, 32'd1);
        issue(3'd3, 2'd1, 3'd1, 1'b0, 32'h1000, 32'h0, 1'b0, 2'd0, 32'h0);
        chk("R3 word next", base_next_o, 32'h1002);
        issue(3'd3, 2'd2, 3'd1, 1'b0, 32'h1000, 32'h0, 1'b0, 2'd0, 32'h0);
        chk("R3 long next", base_next_o, 32'h1004);
        issue(3'd3, 2'd3, 3'd1, 1'b0, 32'hFFFF_FFFC, 32'h0, 1'b0, 2'd0, 32'h0);
        chk("R8 wrap next", base_next_o, 32'h0);
        issue(3'd3, 2'd0, 3'd7, 1'b0, 32'h1000, 32'h0, 1'b0, 2'd0, 32'h0);
        chk("R5 sp byte next", base_next_o, 32'h1002);
        chk("R5 sp byte ea", ea_o, 32'h1000);
    endtask

    task automatic t_predec();
        issue(3'd4, 2'd2, 3'd2, 1'b0, 32'h1000, 32'h0, 1'b0, 2'd0, 32'h0);
        chk("R4 long ea", ea_o, 32'h0FFC);
        chk("R4 long next", base_next_o, 32'h0FFC);
        chk("R10 predec we", {31'd0, base_we_o}, 32'd1);
        issue(3'd4, 2'd0, 3'd3, 1'b0, 32'h1000, 32'h0, 1'b0, 2'd0, 32'h0);
        chk("R4 byte ea", ea_o, 32'h0FFF);
        issue(3'd4, 2'd0, 3'd7, 1'b0, 32'h1000, 32'h0, 1'b0, 2'd0, 32'h0);
        chk("R5 sp predec ea", ea_o, 32'h0FFE);
        issue(3'd4, 2'd1, 3'd7, 1'b0, 32'h1000, 32'h0, 1'b0, 2'd0, 32'h0);
        chk("R5 sp word unchanged", ea_o, 32'h0FFE);
    endtask

    task automatic t_offset();
        issue(3'd5, 2'd1, 3'd1, 1'b0, 32'd2000, 32'h0, 1'b0, 2'd0, 32'd100);
        chk("R6 positive", ea_o, 32'd2100);
        issue(3'd5, 2'd1, 3'd1, 1'b0, 32'd2000, 32'h0, 1'b0, 2'd0, 32'hABCD_FFFF);
        chk("R6 negative", ea_o, 32'd1999);
        chk("R10 offset we", {31'd0, base_we_o}, 32'd0);
    endtask

    task automatic t_indexed();
        issue(3'd6, 2'd1, 3'd1, 1'b0, 32'd2000, 32'd100, 1'b0, 2'd0, 32'h0000_00FF);
        chk("R7 d8 neg word idx", ea_o, 32'd2099);
        issue(3'd6, 2'd1, 3'd1, 1'b0, 32'd2000, 32'h0000_FFFF, 1'b0, 2'd2, 32'd10);
        chk("R8 word idx x4", ea_o, 32'd2006);
        issue(3'd6, 2'd1, 3'd1, 1'b0, 32'd2000, 32'h0000_FFFF, 1'b1, 2'd0, 32'd10);
        chk("R7 long idx", ea_o, 32'd2010 + 32'h0000_FFFF);
        issue(3'd6, 2'd1, 3'd1, 1'b0, 32'd2000, 32'd100, 1'b1, 2'd1, 32'd10);
        chk("R8 long idx x2", ea_o, 32'd2210);
        issue(3'd6, 2'd1, 3'd1, 1'b0, 32'd2000, 32'd100, 1'b0, 2'd3, 32'd10);
        chk("R8 x8", ea_o, 32'd2810);
    endtask

    task automatic t_pc_base();
        issue(3'd5, 2'd1, 3'd7, 1'b1, 32'h0000_0400, 32'h0, 1'b0, 2'd0, 32'h10);
        chk("R9 pc offset", ea_o, 32'h0000_0410);
        issue(3'd6, 2'd1, 3'd7, 1'b1, 32'h0000_0400, 32'd4, 1'b0, 2'd1, 32'hFE);
        chk("R9 pc indexed", ea_o, 32'h0000_0406);
        issue(3'd3, 2'd0, 3'd7, 1'b1, 32'h0000_0400, 32'h0, 1'b0, 2'd0, 32'h0);
        chk("R9 pc no sp rule", base_next_o, 32'h0000_0401);
        chk("R10 pc no we", {31'd0, base_we_o}, 32'd0);
    endtask

    task automatic t_idle();
        req_valid = 1'b0; mode_i = 3'd3; base_pc_i = 1'b0;
        @(negedge clk);
        chk("R11 idle valid", {31'd0, res_valid_o}, 32'd0);
        chk("R10 idle we", {31'd0, base_we_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_absolute();
        t_indirect();
        t_postinc();
        t_predec();
        t_offset();
        t_indexed();
        t_pc_base();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule